// File: doc/BRIEF.md
# Byte-Lane Write Delay Centering Trainer

This controller finds the middle of the passing write-delay window for every byte lane of a memory channel. It runs a shared test on all lanes at once. After each test it reads back one pass/fail bit per lane and decides, lane by lane, whether to advance that lane's delay by one step. An external delay stepper carries out the advance. The block never sets an absolute delay. It only issues single-step strobes and counts them.

A run has two phases. In the first phase the block steps each lane until the lane has passed consistently, which marks the lower edge of the window. In the second phase it keeps stepping until the lane has failed consistently, which marks the upper edge. Both recorded step counts are pulled back by a fixed trim, and the per-lane centre is their mean. A separate controller uses the centre to step the lane back into place. If the stepper reports that it ran out of range, the run stops with an error flag.

Top module: `wr_window_trainer`

## Requirements
- R1: After reset, `busy`, `done`, `testReq`, `trainErr` and every `stepStrb` bit are 0, and the `centre` bus is all zero.
- R2: A `start` pulse while idle begins a run. Each test iteration raises `testReq` for exactly one cycle and covers all lanes. The block then waits for `testDone`. A run whose windows give passes at step counts [lo_i, hi_i) uses max(lo_i)+11 tests in the first phase and max(hi_i-lo_i)+1 tests in the second phase.
- R3: `testFail[i]`=1 means lane i failed. When an active lane's bit differs from the wanted outcome (pass in phase one, fail in phase two), that lane gets one `stepStrb[i]` pulse and its step counter is incremented.
- R4: When an active lane shows the wanted outcome and its consistency count is below 10, the lane is still stepped and counted, and its consistency count is incremented. An unwanted result does not clear the consistency count. When the lane shows the wanted outcome with the count at 10, it is frozen: it gets no further strobes for the rest of the phase.
- R5: A phase ends when no lane is active. At the start of phase two, every consistency count is cleared and every lane is active again. Step counters keep their phase-one values, and those values are recorded as the lower edges.
- R6: At the end of phase two, lane i's value on `centre[i*8 +: 8]` is ((lower-9)+(upper-9))/2, rounded down. For a clean window [lo,hi) with hi-lo ≥ 11 this equals (lo+hi+2)/2.
- R7: If `stepErr` is high in the cycle that follows a strobe cycle, the run aborts. `trainErr` goes to 1, `done` pulses, no further strobes follow, and `centre` stays zero. The next `start` clears `trainErr`.
- R8: `done` is a single-cycle pulse that ends every run. `centre` keeps its value until the next accepted `start`. A `start` that arrives while busy is ignored.
- R9: `testDone` has no effect while the block is idle: no test request, no strobe, no run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a training run (taken only when idle) |
| testDone | input | 1 | Tester finished; `testFail` is valid this cycle |
| testFail | input | LANES | Per-lane failure flag, 1 = failed |
| stepErr | input | 1 | Stepper overflow, valid the cycle after a strobe |
| testReq | output | 1 | One-cycle request for a test on all lanes |
| stepStrb | output | LANES | Per-lane one-step delay advance pulse |
| busy | output | 1 | Run in progress (includes the done cycle) |
| done | output | 1 | One-cycle end-of-run pulse |
| trainErr | output | 1 | Run aborted on stepper overflow |
| centre | output | LANES*CNT_W | Per-lane centre step counts |

## Verification
`testReq` is high in the second cycle after `start` is sampled. The strobes come two cycles after the edge that samples `testDone`. The stepper's error is sampled one cycle after the strobe, and `done` is high one cycle after the final decision, which is also the first cycle in which `centre` holds its new value. The bench's tester and stepper models act on falling edges. They count strobes and requests as these appear, answer a request one cycle later, and return overflow one cycle after the strobe that caused it. Results are compared only after `done` has been seen and a few more cycles have passed.

// File: rtl/wwt_pkg.sv
package wwt_pkg;
  typedef struct packed {
    logic clearAll;
    logic evalEn;
    logic stepOut;
    logic phaseNext;
    logic finish;
    logic wantFail;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_STEP, ST_CHK, ST_FIN, ST_DONE
  } state_t;
endpackage

// File: rtl/wwt_lane.sv
module wwt_lane
  import wwt_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int CONSIST   = 10,
  parameter int EDGE_TRIM = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic             laneFail,
  output logic             active,
  output logic             stepPend,
  output logic [CNT_W-1:0] centre
);
  localparam int CONS_W = $clog2(CONSIST + 1);
  localparam logic [CONS_W-1:0] CONS_LIM = CONS_W'(CONSIST);
  localparam logic [CNT_W:0] TRIM = (CNT_W + 1)'(EDGE_TRIM);

  logic [CNT_W-1:0]  stepCnt;
  logic [CNT_W-1:0]  lowRec;
  logic [CONS_W-1:0] consCnt;
  logic [CNT_W:0]    lowAdj;
  logic [CNT_W:0]    upAdj;
  logic [CNT_W:0]    sumAdj;
  logic              wanted;

  assign wanted = (laneFail == ctrl.wantFail);
  assign lowAdj = {1'b0, lowRec} - TRIM;
  assign upAdj  = {1'b0, stepCnt} - TRIM;
  assign sumAdj = lowAdj + upAdj;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt  <= '0;
      lowRec   <= '0;
      consCnt  <= '0;
      active   <= 1'b0;
      stepPend <= 1'b0;
      centre   <= '0;
    end else if (ctrl.clearAll) begin
      stepCnt  <= '0;
      lowRec   <= '0;
      consCnt  <= '0;
      active   <= 1'b1;
      stepPend <= 1'b0;
      centre   <= '0;
    end else begin
      if (ctrl.evalEn) begin
        stepPend <= 1'b0;
        if (active) begin
          if (!wanted) begin
            stepPend <= 1'b1;
            stepCnt  <= stepCnt + 1'b1;
          end else if (consCnt != CONS_LIM) begin
            stepPend <= 1'b1;
            stepCnt  <= stepCnt + 1'b1;
            consCnt  <= consCnt + 1'b1;
          end else begin
            active <= 1'b0;
          end
        end
      end else if (ctrl.stepOut) begin
        stepPend <= 1'b0;
      end
      if (ctrl.phaseNext) begin
        lowRec  <= stepCnt;
        consCnt <= '0;
        active  <= 1'b1;
      end
      if (ctrl.finish) begin
        centre <= sumAdj[CNT_W:1];
      end
    end
  end
endmodule

// File: rtl/wwt_datapath.sv
module wwt_datapath
  import wwt_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int CNT_W     = 8,
  parameter int CONSIST   = 10,
  parameter int EDGE_TRIM = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtrl_t                ctrl,
  input  logic [LANES-1:0]       testFail,
  output logic [LANES-1:0]       stepStrb,
  output logic                   anyActive,
  output logic [LANES*CNT_W-1:0] centre
);
  logic [LANES-1:0] activeVec;
  logic [LANES-1:0] pendVec;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wwt_lane #(
      .CNT_W    (CNT_W),
      .CONSIST  (CONSIST),
      .EDGE_TRIM(EDGE_TRIM)
    ) u_lane (
      .clk     (clk),
      .rstN    (rstN),
      .ctrl    (ctrl),
      .laneFail(testFail[i]),
      .active  (activeVec[i]),
      .stepPend(pendVec[i]),
      .centre  (centre[i*CNT_W +: CNT_W])
    );
  end

  assign stepStrb  = pendVec & {LANES{ctrl.stepOut}};
  assign anyActive = |activeVec;
endmodule

// File: rtl/wwt_ctrl.sv
module wwt_ctrl
  import wwt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    testDone,
  input  logic    stepErr,
  input  logic    anyActive,
  output dpCtrl_t ctrl,
  output logic    testReq,
  output logic    busy,
  output logic    done,
  output logic    trainErr
);
  state_t state, nextState;
  logic   wantFail;
  logic   errQ;

  always_comb begin
    ctrl          = '0;
    ctrl.wantFail = wantFail;
    nextState     = state;
    unique case (state)
      ST_IDLE: if (start) begin
        ctrl.clearAll = 1'b1;
        nextState     = ST_REQ;
      end
      ST_REQ:  nextState = ST_WAIT;
      ST_WAIT: if (testDone) begin
        ctrl.evalEn = 1'b1;
        nextState   = ST_STEP;
      end
      ST_STEP: begin
        ctrl.stepOut = 1'b1;
        nextState    = ST_CHK;
      end
      ST_CHK: begin
        if (stepErr) begin
          nextState = ST_DONE;
        end else if (anyActive) begin
          nextState = ST_REQ;
        end else if (!wantFail) begin
          ctrl.phaseNext = 1'b1;
          nextState      = ST_REQ;
        end else begin
          nextState = ST_FIN;
        end
      end
      ST_FIN: begin
        ctrl.finish = 1'b1;
        nextState   = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wantFail <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      state <= nextState;
      if (ctrl.clearAll) begin
        wantFail <= 1'b0;
        errQ     <= 1'b0;
      end
      if (ctrl.phaseNext) wantFail <= 1'b1;
      if (state == ST_CHK && stepErr) errQ <= 1'b1;
    end
  end

  assign testReq  = (state == ST_REQ);
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign trainErr = errQ;
endmodule

// File: rtl/wr_window_trainer.sv
module wr_window_trainer
  import wwt_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int CNT_W     = 8,
  parameter int CONSIST   = 10,
  parameter int EDGE_TRIM = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   testDone,
  input  logic [LANES-1:0]       testFail,
  input  logic                   stepErr,
  output logic                   testReq,
  output logic [LANES-1:0]       stepStrb,
  output logic                   busy,
  output logic                   done,
  output logic                   trainErr,
  output logic [LANES*CNT_W-1:0] centre
);
  dpCtrl_t ctrl;
  logic    anyActive;

  wwt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .testDone (testDone),
    .stepErr  (stepErr),
    .anyActive(anyActive),
    .ctrl     (ctrl),
    .testReq  (testReq),
    .busy     (busy),
    .done     (done),
    .trainErr (trainErr)
  );

  wwt_datapath #(
    .LANES    (LANES),
    .CNT_W    (CNT_W),
    .CONSIST  (CONSIST),
    .EDGE_TRIM(EDGE_TRIM)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .testFail (testFail),
    .stepStrb (stepStrb),
    .anyActive(anyActive),
    .centre   (centre)
  );
endmodule

// File: rtl/wwt_checker.sv
module wwt_checker #(
  parameter int LANES = 8,
  parameter int CNT_W = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic                   testReq,
  input logic [LANES-1:0]       stepStrb,
  input logic                   busy,
  input logic                   done,
  input logic                   trainErr,
  input logic [LANES*CNT_W-1:0] centre
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (stepStrb == '0 && !testReq));

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    testReq |=> !testReq);

  // R3
  step_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrb != '0) |=> (stepStrb == '0 && !testReq));

  // R7
  err_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trainErr) |-> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  centre_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(centre));
endmodule

bind wr_window_trainer wwt_checker #(.LANES(LANES), .CNT_W(CNT_W)) u_wwt_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .testReq (testReq),
  .stepStrb(stepStrb),
  .busy    (busy),
  .done    (done),
  .trainErr(trainErr),
  .centre  (centre)
);

// File: tb/tb_wr_window_trainer.sv
module tb_wr_window_trainer;
  localparam int LANES   = 8;
  localparam int CW      = 8;
  localparam int MAXSTEP = 63;
  localparam int ROWS    = 4;
  // each row: lower-edge base, per-lane stride, window width
  localparam int TBL[ROWS][3] = '{'{0, 1, 12}, '{3, 2, 20}, '{12, 0, 15}, '{5, 3, 11}};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rstN, start, testDone, stepErr;
  logic [LANES-1:0]    testFail;
  logic                testReq, busy, done, trainErr;
  logic [LANES-1:0]    stepStrb;
  logic [LANES*CW-1:0] centre;

  int checks = 0, errors = 0;
  int lo[LANES], hi[LANES], gl[LANES], cnt[LANES];
  int doneCnt, reqCnt;
  bit forceDone, respPend, pendErr;

  wr_window_trainer dut (
    .clk(clk), .rstN(rstN), .start(start), .testDone(testDone),
    .testFail(testFail), .stepErr(stepErr), .testReq(testReq),
    .stepStrb(stepStrb), .busy(busy), .done(done), .trainErr(trainErr),
    .centre(centre)
  );

  function automatic bit lanePass(int i, int s);
    return (s >= lo[i] && s < hi[i]) || (s == gl[i]);
  endfunction

  // tester and stepper models, acting on falling edges
  initial begin
    testDone = 1'b0; testFail = '0; stepErr = 1'b0;
    respPend = 1'b0; pendErr = 1'b0;
    forever begin
      @(negedge clk);
      stepErr = pendErr;
      pendErr = 1'b0;
      for (int i = 0; i < LANES; i++) begin
        if (stepStrb[i]) begin
          cnt[i]++;
          if (cnt[i] > MAXSTEP) pendErr = 1'b1;
        end
      end
      if (done) doneCnt++;
      if (testReq) reqCnt++;
      testDone = forceDone;
      if (respPend) begin
        testDone = 1'b1;
        for (int i = 0; i < LANES; i++) testFail[i] = !lanePass(i, cnt[i]);
        respPend = 1'b0;
      end
      if (testReq) respPend = 1'b1;
    end
  end

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int laneCentre(int i);
    return int'(centre[i*CW +: CW]);
  endfunction

  task automatic pulseStart();
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
  endtask

  task automatic runTrain(bit midStart);
    int guard;
    for (int i = 0; i < LANES; i++) cnt[i] = 0;
    doneCnt = 0; reqCnt = 0;
    pulseStart();
    if (midStart) begin
      repeat (20) @(posedge clk);
      #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
    end
    guard = 0;
    while (doneCnt == 0 && guard < 8000) begin
      @(posedge clk);
      guard++;
    end
    repeat (4) @(posedge clk);
    #2;
  endtask

  task automatic loadRow(int r);
    for (int i = 0; i < LANES; i++) begin
      lo[i] = TBL[r][0] + TBL[r][1] * i;
      hi[i] = lo[i] + TBL[r][2];
      gl[i] = 1000;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; forceDone = 1'b0;
    doneCnt = 0; reqCnt = 0;
    for (int i = 0; i < LANES; i++) begin
      lo[i] = 0; hi[i] = 12; gl[i] = 1000; cnt[i] = 0;
    end
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 busy", busy, 0);
    checkEq("R1 done", done, 0);
    checkEq("R1 testReq", testReq, 0);
    checkEq("R1 trainErr", trainErr, 0);
    checkEq("R1 stepStrb", int'(stepStrb), 0);
    checkEq("R1 centre zero", int'(centre != '0), 0);

    // R9 spurious testDone while idle
    @(posedge clk); #2 forceDone = 1'b1;
    repeat (2) @(posedge clk); #2 forceDone = 1'b0;
    repeat (4) @(posedge clk); #2;
    checkEq("R9 busy after idle testDone", busy, 0);
    checkEq("R9 no request", reqCnt, 0);
    checkEq("R9 no strobes", cnt[0] + cnt[7], 0);

    // table of windows
    for (int r = 0; r < ROWS; r++) begin
      int maxLo;
      loadRow(r);
      maxLo = lo[LANES-1] > lo[0] ? lo[LANES-1] : lo[0];
      runTrain(1'b0);
      checkEq($sformatf("R7 no error row %0d", r), trainErr, 0);
      checkEq($sformatf("R8 done pulses row %0d", r), doneCnt, 1);
      checkEq($sformatf("R2 test count row %0d", r), reqCnt, maxLo + 12 + TBL[r][2]);
      for (int i = 0; i < LANES; i++) begin
        checkEq($sformatf("R6 R5 centre row %0d lane %0d", r, i), laneCentre(i),
                (lo[i] + hi[i] + 2) / 2);
        checkEq($sformatf("R3 R4 steps row %0d lane %0d", r, i), cnt[i], hi[i] + 10);
      end
    end

    // R4: a stray pass before the window counts toward consistency
    for (int i = 0; i < LANES; i++) begin lo[i] = 2; hi[i] = 20; gl[i] = 1000; end
    lo[0] = 20; hi[0] = 40; gl[0] = 5;
    runTrain(1'b0);
    checkEq("R4 stray pass centre lane0", laneCentre(0), 30);
    checkEq("R4 stray pass steps lane0", cnt[0], 50);
    checkEq("R5 other lane centre", laneCentre(1), 12);
    repeat (30) @(posedge clk); #2;
    checkEq("R8 centre held lane0", laneCentre(0), 30);
    checkEq("R8 centre held lane1", laneCentre(1), 12);

    // R8: start while busy is ignored
    loadRow(0);
    runTrain(1'b1);
    checkEq("R8 single done with extra start", doneCnt, 1);
    checkEq("R8 request count unchanged", reqCnt, 31);
    checkEq("R8 centre lane3 with extra start", laneCentre(3), (lo[3] + hi[3] + 2) / 2);

    // R7: stepper overflow aborts
    for (int i = 0; i < LANES; i++) begin lo[i] = 0; hi[i] = 12; gl[i] = 1000; end
    lo[3] = 70; hi[3] = 90;
    runTrain(1'b0);
    checkEq("R7 error flag", trainErr, 1);
    checkEq("R7 done pulse", doneCnt, 1);
    checkEq("R7 centre stays zero", int'(centre != '0), 0);
    checkEq("R7 no strobes after overflow", cnt[3], MAXSTEP + 1);
    checkEq("R4 frozen lane not stepped", cnt[0], 10);

    // R7: next start clears the error
    loadRow(1);
    runTrain(1'b0);
    checkEq("R7 error cleared on start", trainErr, 0);
    checkEq("R6 centre after recovery lane5", laneCentre(5), (lo[5] + hi[5] + 2) / 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule